// File: doc/BRIEF.md
# Link Training Clock-Recovery Sequencer

This block runs the clock-recovery phase of link training for a serial display link of up to four lanes. On a start pulse it captures the number of active lanes and a programmable wait interval. It drives training pattern 1 and sets every active lane to the lowest drive level. It then repeats a fixed loop: wait the programmed interval, sample the packed lane-status bytes and adjust-request bytes, and either finish or apply the requested drive levels.

Each requested swing and pre-emphasis pair is clamped so that the two never add up to more than 3. Each lane-set output byte carries flags that show whether that lane's swing or pre-emphasis has reached its maximum. Training passes when every active lane reports clock recovery done. It fails when the sink asks for the same levels too many times in a row, or when the total number of attempts runs out. A one-cycle done pulse reports the result, and the training pattern returns to none in the same cycle.

The surrounding link controller moves the status and adjust bytes over the auxiliary channel. It consumes the lane-set bytes and the pattern select, and it owns the equalisation phase that follows.

Top module: `lt_cr_seq`

## Requirements
- R1: After reset, `done`, `pass` and `busy` are 0, `train_pat` is 0 (none) and `lane_set` is all zero.
- R2: A `start` pulse while idle sets `busy` and sets `train_pat` to 1 (pattern 1) on the next clock edge. Every lane-set byte reads 0x00 at that point, meaning swing 0 and pre-emphasis 0 with neither max flag set.
- R3: Each attempt takes `wait_cycles`+2 clock cycles. `lane_status` and `adjust_req` are sampled on the last edge of the attempt, and `done` stays 0 before that edge.
- R4: Lane i uses byte i/2 of `lane_status` and `adjust_req`, in the low nibble for even i and the high nibble for odd i. In `lane_status`, bit 0 of the nibble is clock-recovery done. The sequence passes when that bit is set for every active lane.
- R5: In `adjust_req`, nibble bits 1:0 are the requested swing and bits 3:2 the requested pre-emphasis. If their sum exceeds 3, the pre-emphasis is reduced to 3 minus the swing. Lane-set byte i holds swing in bits 1:0, swing-max in bit 2, pre-emphasis in bits 4:3 and pre-emphasis-max in bit 5, with bits 7:6 zero. Swing-max is set when swing ≥ 3 − pre-emphasis, and pre-emphasis-max when pre-emphasis ≥ 3 − swing.
- R6: After each failed attempt, a same-level counter increments when the clamped requests of all active lanes equal their current levels, and clears to 0 otherwise. Training fails when the counter reaches 7.
- R7: Training fails on the 15th attempt when clock recovery is still not done on that attempt.
- R8: `done` is a one-cycle pulse. `pass` is 1 only together with `done` and only on success. `train_pat` and `busy` are 0 from the done cycle onward.
- R9: Lanes at or above the active lane count (1, 2 or 4) are ignored: their status and adjust bits have no effect and their lane-set bytes stay 0x00.
- R10: A `start` pulse while `busy` has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a clock-recovery sequence when idle |
| lane_cnt | input | 3 | Active lane count (1, 2 or 4), captured at start |
| wait_cycles | input | 16 | Wait interval per attempt, captured at start |
| lane_status | input | 16 | Packed per-lane status nibbles, two lanes per byte |
| adjust_req | input | 16 | Packed per-lane adjust requests, two lanes per byte |
| lane_set | output | 32 | One drive-setting byte per lane |
| train_pat | output | 2 | Training pattern select: 0 none, 1 pattern 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |

## Verification
The bench targets three corner cases. The first is a sink that always repeats the current levels, which must end on exactly the 7th attempt. A design that compares raw requests instead of clamped ones, or that resets the counter wrongly, ends early or runs on to the total limit. The second is a sink that alternates its requests forever, which must end on the 15th attempt; an off-by-one counter ends one attempt early or late. The third covers requests with swing plus pre-emphasis above 3, garbage in the inactive lanes and stray start pulses. A design without the clamp, the lane mask or the busy guard shows a wrong lane-set byte, passes or fails on the wrong lane, or restarts mid-sequence, and each of these shifts the attempt timing the bench predicts.

// File: rtl/lt_cr_pkg.sv
package lt_cr_pkg;

  localparam int LVL_TOP = 3;

  typedef struct packed {
    logic [1:0] pe;
    logic [1:0] sw;
  } drive_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_CHECK = 2'd2
  } seq_st_t;

  // swing reached its ceiling for the given pre-emphasis
  function automatic logic sw_is_max(drive_t d);
    return {1'b0, d.sw} >= (3'(LVL_TOP) - {1'b0, d.pe});
  endfunction

  // pre-emphasis reached its ceiling for the given swing
  function automatic logic pe_is_max(drive_t d);
    return {1'b0, d.pe} >= (3'(LVL_TOP) - {1'b0, d.sw});
  endfunction

  // keep swing, trim pre-emphasis so the pair fits the shared budget
  function automatic drive_t fit_drive(drive_t req);
    drive_t r;
    r = req;
    if (({1'b0, req.sw} + {1'b0, req.pe}) > 3'(LVL_TOP))
      r.pe = 2'(LVL_TOP) - req.sw;
    return r;
  endfunction

  function automatic logic [7:0] lane_set_byte(drive_t d);
    return {2'b00, pe_is_max(d), d.pe, sw_is_max(d), d.sw};
  endfunction

endpackage

// File: rtl/lt_cr_lane.sv
module lt_cr_lane
  import lt_cr_pkg::*;
(
  input  logic       active,
  input  logic [3:0] stat_nib,
  input  logic [3:0] req_nib,
  input  drive_t     cur,
  output drive_t     req_fit,
  output logic       lane_ok,
  output logic       lane_same,
  output logic [7:0] set_byte
);

  drive_t req_raw;
  logic   stat_unused;

  assign stat_unused = ^stat_nib[3:1];

  always_comb begin
    req_raw.sw = req_nib[1:0];
    req_raw.pe = req_nib[3:2];
    req_fit    = fit_drive(req_raw);
  end

  assign lane_ok   = !active || stat_nib[0];
  assign lane_same = !active || (req_fit == cur);
  assign set_byte  = active ? lane_set_byte(cur) : 8'h00;

endmodule

// File: rtl/lt_cr_drive_reg.sv
module lt_cr_drive_reg
  import lt_cr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   load,
  input  logic   active,
  input  drive_t d,
  output drive_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clear)            q <= '0;
    else if (load && active)   q <= d;
  end

endmodule

// File: rtl/lt_cr_ctrl.sv
module lt_cr_ctrl
  import lt_cr_pkg::*;
#(
  parameter int WAIT_W      = 16,
  parameter int SAME_LIMIT  = 7,
  parameter int TOTAL_LIMIT = 15,
  localparam int SAME_W     = $clog2(SAME_LIMIT + 1),
  localparam int TOT_W      = $clog2(TOTAL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic              all_ok,
  input  logic              all_same,
  output logic              init_evt,
  output logic              apply_evt,
  output logic              chk_evt,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        train_pat,
  output logic [SAME_W-1:0] same_cnt,
  output logic [TOT_W-1:0]  total_cnt
);

  seq_st_t           st;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] wcnt;
  logic [SAME_W-1:0] same_nxt;
  logic              last_total;
  logic              same_hit;
  logic              give_up;
  logic              finish_ok;
  logic              finish_bad;

  always_comb begin
    same_nxt   = all_same ? same_cnt + 1'b1 : '0;
    last_total = (total_cnt == TOT_W'(TOTAL_LIMIT - 1));
    same_hit   = (same_nxt == SAME_W'(SAME_LIMIT));
    give_up    = last_total || same_hit;
    chk_evt    = (st == ST_CHECK);
    finish_ok  = chk_evt && all_ok;
    finish_bad = chk_evt && !all_ok && give_up;
    apply_evt  = chk_evt && !all_ok && !give_up;
    init_evt   = (st == ST_IDLE) && start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wait_q    <= '0;
      wcnt      <= '0;
      same_cnt  <= '0;
      total_cnt <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      train_pat <= 2'd0;
    end else begin
      done <= 1'b0;
      pass <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            wait_q    <= wait_cycles;
            wcnt      <= wait_cycles;
            same_cnt  <= '0;
            total_cnt <= '0;
            busy      <= 1'b1;
            train_pat <= 2'd1;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wcnt == '0) st <= ST_CHECK;
          else            wcnt <= wcnt - 1'b1;
        end
        ST_CHECK: begin
          total_cnt <= total_cnt + 1'b1;
          if (finish_ok || finish_bad) begin
            done      <= 1'b1;
            pass      <= finish_ok;
            busy      <= 1'b0;
            train_pat <= 2'd0;
            st        <= ST_IDLE;
          end else begin
            same_cnt <= same_nxt;
            wcnt     <= wait_q;
            st       <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lt_cr_seq.sv
module lt_cr_seq
  import lt_cr_pkg::*;
#(
  parameter int MAX_LANES   = 4,
  parameter int WAIT_W      = 16,
  parameter int SAME_LIMIT  = 7,
  parameter int TOTAL_LIMIT = 15,
  localparam int CNT_W      = $clog2(MAX_LANES + 1),
  localparam int STAT_W     = 8 * ((MAX_LANES + 1) / 2),
  localparam int SET_W      = 8 * MAX_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  lane_cnt,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [STAT_W-1:0] lane_status,
  input  logic [STAT_W-1:0] adjust_req,
  output logic [SET_W-1:0]  lane_set,
  output logic [1:0]        train_pat,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  localparam int SAME_W = $clog2(SAME_LIMIT + 1);
  localparam int TOT_W  = $clog2(TOTAL_LIMIT + 1);

  logic [CNT_W-1:0]     cfg_lanes;
  logic [MAX_LANES-1:0] act_vec;
  logic [MAX_LANES-1:0] ok_vec;
  logic [MAX_LANES-1:0] same_vec;
  drive_t               cur_q [MAX_LANES];
  drive_t               fit_d [MAX_LANES];
  logic                 init_evt;
  logic                 apply_evt;
  logic                 chk_evt;
  logic [SAME_W-1:0]    same_cnt;
  logic [TOT_W-1:0]     total_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_lanes <= '0;
    else if (init_evt) cfg_lanes <= lane_cnt;
  end

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    localparam int NIB = 8 * (i / 2) + 4 * (i % 2);

    assign act_vec[i] = (CNT_W'(i) < cfg_lanes);

    lt_cr_lane i_lane (
      .active    (act_vec[i]),
      .stat_nib  (lane_status[NIB +: 4]),
      .req_nib   (adjust_req[NIB +: 4]),
      .cur       (cur_q[i]),
      .req_fit   (fit_d[i]),
      .lane_ok   (ok_vec[i]),
      .lane_same (same_vec[i]),
      .set_byte  (lane_set[8*i +: 8])
    );

    lt_cr_drive_reg i_drv (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (init_evt),
      .load   (apply_evt),
      .active (act_vec[i]),
      .d      (fit_d[i]),
      .q      (cur_q[i])
    );
  end

  if (STAT_W > 8 * ((MAX_LANES + 1) / 2) - 1) begin : g_pad_none
  end

  lt_cr_ctrl #(
    .WAIT_W      (WAIT_W),
    .SAME_LIMIT  (SAME_LIMIT),
    .TOTAL_LIMIT (TOTAL_LIMIT)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .wait_cycles (wait_cycles),
    .all_ok      (&ok_vec),
    .all_same    (&same_vec),
    .init_evt    (init_evt),
    .apply_evt   (apply_evt),
    .chk_evt     (chk_evt),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .train_pat   (train_pat),
    .same_cnt    (same_cnt),
    .total_cnt   (total_cnt)
  );

endmodule

// File: rtl/lt_cr_seq_chk.sv
module lt_cr_seq_chk #(
  parameter int MAX_LANES   = 4,
  parameter int SAME_LIMIT  = 7,
  parameter int TOTAL_LIMIT = 15,
  localparam int CNT_W      = $clog2(MAX_LANES + 1),
  localparam int SET_W      = 8 * MAX_LANES,
  localparam int SAME_W     = $clog2(SAME_LIMIT + 1),
  localparam int TOT_W      = $clog2(TOTAL_LIMIT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SET_W-1:0]  lane_set,
  input logic [1:0]        train_pat,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              chk_evt,
  input logic [CNT_W-1:0]  cfg_lanes,
  input logic [SAME_W-1:0] same_cnt,
  input logic [TOT_W-1:0]  total_cnt
);

  function automatic logic bytes_legal(logic [SET_W-1:0] ls);
    for (int i = 0; i < MAX_LANES; i++) begin
      int s, p;
      s = int'(ls[8*i +: 2]);
      p = int'(ls[8*i+3 +: 2]);
      if (s + p > 3) return 1'b0;
      if (ls[8*i+2] != (s + p == 3)) return 1'b0;
      if (ls[8*i+5] != (s + p == 3)) return 1'b0;
      if (ls[8*i+6 +: 2] != 2'b00) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic idle_lanes_zero(logic [SET_W-1:0] ls, logic [CNT_W-1:0] n);
    for (int i = 0; i < MAX_LANES; i++)
      if (i >= int'(n) && ls[8*i +: 8] != 8'h00) return 1'b0;
    return 1'b1;
  endfunction

  a_r1_pattern_legal: assert property (@(posedge clk) disable iff (!rst_n)
    train_pat <= 2'd1);

  a_r2_start_levels_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (lane_set == '0) && (train_pat == 2'd1));

  a_r3_done_after_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(chk_evt));

  a_r5_lane_bytes_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bytes_legal(lane_set));

  a_r6_same_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    same_cnt < SAME_W'(SAME_LIMIT));

  a_r7_total_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    total_cnt <= TOT_W'(TOTAL_LIMIT));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (train_pat == 2'd0) && !busy);

  a_r8_pass_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  a_r9_idle_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    idle_lanes_zero(lane_set, cfg_lanes));

endmodule

bind lt_cr_seq lt_cr_seq_chk #(
  .MAX_LANES   (MAX_LANES),
  .SAME_LIMIT  (SAME_LIMIT),
  .TOTAL_LIMIT (TOTAL_LIMIT)
) i_lt_cr_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lane_set  (lane_set),
  .train_pat (train_pat),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .chk_evt   (chk_evt),
  .cfg_lanes (cfg_lanes),
  .same_cnt  (same_cnt),
  .total_cnt (total_cnt)
);

// File: tb/test_lt_cr_seq.sv
module test_lt_cr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  lane_cnt = '0;
  logic [15:0] wait_cycles = '0;
  logic [15:0] lane_status = '0;
  logic [15:0] adjust_req = '0;
  logic [31:0] lane_set;
  logic [1:0]  train_pat;
  logic        busy, done, pass;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] st_s [16];
  logic [15:0] ad_s [16];

  always #5 clk = ~clk;

  lt_cr_seq i_lt_cr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
    .wait_cycles(wait_cycles), .lane_status(lane_status), .adjust_req(adjust_req),
    .lane_set(lane_set), .train_pat(train_pat), .busy(busy), .done(done), .pass(pass)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nib_pos(int lane);
    return (lane / 2) * 8 + (lane % 2) * 4;
  endfunction

  function automatic int trim_pe(int s, int p);
    if (s + p > 3) return 3 - s;
    return p;
  endfunction

  function automatic logic [7:0] ref_byte(int s, int p);
    int top;
    top = (s + p >= 3) ? 1 : 0;
    return 8'(s + 4 * top + 8 * p + 32 * top);
  endfunction

  task automatic run_case(int lanes, int w, int noise, int exp_checks, int exp_pass);
    int  sw [4];
    int  pe [4];
    int  same = 0;
    int  k = 0;
    bit  fin = 0;
    bit  e_pass = 0;
    logic [31:0] e_set = '0;
    for (int i = 0; i < 4; i++) begin sw[i] = 0; pe[i] = 0; end
    @(negedge clk);
    lane_cnt = 3'(lanes); wait_cycles = 16'(w);
    lane_status = st_s[0]; adjust_req = ad_s[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy", 64'(busy), 64'd1);
    chk("R2 pattern", 64'(train_pat), 64'd1);
    chk("R2 levels", 64'(lane_set), 64'd0);
    while (!fin && k < 16) begin
      for (int m = 1; m <= w + 2; m++) begin
        @(negedge clk);
        start = (noise != 0) && (m <= w + 1);
        if (m == w + 1) chk("R3 no early done", 64'(done), 64'd0);
      end
      begin
        bit all_ok = 1;
        bit all_same = 1;
        int ns [4];
        int np [4];
        for (int i = 0; i < lanes; i++) begin
          int a;
          a = int'(ad_s[k] >> nib_pos(i));
          ns[i] = a & 3;
          np[i] = trim_pe(ns[i], (a >> 2) & 3);
          if (st_s[k][nib_pos(i)] == 1'b0) all_ok = 0;
          if (ns[i] != sw[i] || np[i] != pe[i]) all_same = 0;
        end
        if (all_ok) begin
          fin = 1; e_pass = 1;
        end else if (k + 1 == 15) begin
          fin = 1; e_pass = 0;
        end else begin
          same = all_same ? same + 1 : 0;
          if (same == 7) begin
            fin = 1; e_pass = 0;
          end else begin
            for (int i = 0; i < lanes; i++) begin
              sw[i] = ns[i]; pe[i] = np[i];
              e_set[8*i +: 8] = ref_byte(sw[i], pe[i]);
            end
          end
        end
      end
      chk("R4 R6 R7 done at attempt", 64'(done), 64'(fin));
      chk("R4 R8 pass", 64'(pass), 64'(fin && e_pass));
      chk("R8 pattern", 64'(train_pat), fin ? 64'd0 : 64'd1);
      if (!fin) chk("R5 R9 lane bytes", 64'(lane_set), 64'(e_set));
      k++;
      if (fin) begin
        @(negedge clk);
        chk("R8 done pulse width", 64'(done), 64'd0);
        chk("R8 busy cleared", 64'(busy), 64'd0);
      end else begin
        lane_status = st_s[k % 16]; adjust_req = ad_s[k % 16];
      end
    end
    if (exp_checks > 0) chk("R6 R7 attempt count", 64'(k), 64'(exp_checks));
    if (exp_pass >= 0) chk("R4 result", 64'(e_pass), 64'(exp_pass));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0c12);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 pass", 64'(pass), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 pattern", 64'(train_pat), 64'd0);
    chk("R1 lane bytes", 64'(lane_set), 64'd0);

    // R4: all four lanes done on the first attempt
    for (int k = 0; k < 16; k++) begin st_s[k] = 16'h1111; ad_s[k] = 16'h0000; end
    run_case(4, 0, 0, 1, 1);

    // R6: sink repeats the current level forever
    for (int k = 0; k < 16; k++) begin st_s[k] = 16'h0000; ad_s[k] = 16'h0000; end
    run_case(2, 2, 0, 7, 0);

    // R7: sink keeps changing its request
    for (int k = 0; k < 16; k++) begin st_s[k] = 16'h0000; ad_s[k] = (k % 2) ? 16'h0002 : 16'h0001; end
    run_case(4, 0, 0, 15, 0);

    // R9: one lane, garbage in the other lanes
    for (int k = 0; k < 16; k++) begin st_s[k] = 16'hEEE0; ad_s[k] = 16'hFFF0 | 16'(k % 4); end
    st_s[2] = 16'hEEE1;
    run_case(1, 1, 0, 3, 1);

    // R5 clamp with R10 stray start pulses
    for (int k = 0; k < 16; k++) begin st_s[k] = 16'h1111; ad_s[k] = 16'h0000; end
    st_s[0] = 16'h0000; ad_s[0] = 16'h00DF;
    run_case(4, 3, 1, 2, 1);

    for (int n = 0; n < 40; n++) begin
      int lanes;
      lanes = (n % 3 == 0) ? 1 : ((n % 3 == 1) ? 2 : 4);
      for (int k = 0; k < 16; k++) begin
        logic [15:0] cr;
        cr = 16'($urandom) & 16'h1111;
        if ($urandom % 4 != 0) cr = cr | (16'($urandom) & 16'h1111);
        st_s[k] = (16'($urandom) & 16'hEEEE) | cr;
        if (k > 0 && ($urandom % 2 == 0)) ad_s[k] = ad_s[k-1];
        else ad_s[k] = 16'($urandom);
      end
      run_case(lanes, int'($urandom % 4), int'($urandom % 2), 0, -1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule